// File: doc/BRIEF.md
# Serial SAR Conversion Sequencer

This block is the digital half of an eight-input successive-approximation converter driven through a four-wire serial port. While the chip-select is low it watches the serial data line for a start bit. It then collects a control byte from which it derives the analog multiplexer selection and the power/clock mode. It times the acquisition window and runs a 16-step binary search against an external capacitor DAC and a comparator. Each decided bit is shifted out on the data output, MSB first.

The serial inputs are treated as already synchronous to the system clock `clk`. The serial clock is sampled once per `clk` cycle. Each of its high and low phases must last at least two `clk` cycles. Every state change happens on the `clk` edge at which a serial-clock edge is first seen, and all outputs are registered. Conversions always use the serial clock as the conversion clock. The clock-mode selection is only passed on to neighbouring logic.

Top module: `ser_sar_seq`

## Requirements
- R1: While `cs_n_i` is high, `dout_oe_o`, `busy_oe_o`, `busy_o`, `sample_o` and `dout_o` are low one `clk` later. Any partly received byte or running conversion is abandoned, and the next frame needs a fresh start bit.
- R2: DIN is sampled on rising serial-clock edges. Low bits are discarded until the first high bit, which is taken as the start (byte bit 7).
- R3: The control byte arrives MSB first as start, A2, A1, A0, a don't-care bit, single/differential (1 = single-ended), PD1, PD0. In single-ended mode A2A1A0 = 000,100,001,101,010,110,011,111 select inputs 0..7 in that order: `pos_sel_o` is {A1,A0,A2}, `neg_com_o`=1 and `neg_sel_o`=0.
- R4: In differential mode A1A0 picks the pair (2k, 2k+1) and `neg_com_o`=0. With A2=0 the positive input is 2k and the negative input is 2k+1. With A2=1 the two are swapped.
- R5: `sample_o` rises on the rising edge that latches A0 and falls on the rising edge that latches PD0.
- R6: `busy_o` rises on the first falling edge after the eighth control bit and falls on the next falling edge.
- R7: The busy edge sets `dac_code_o` to 0x8000. Each of the next 16 falling edges keeps the bit under test when `cmp_i` is high, drives that decision on `dout_o`, and sets the next lower bit in the trial. The bits on `dout_o` form the straight-binary result, MSB first.
- R8: Outside the 16 decision edges, falling edges drive `dout_o` low. The LSB is held until the falling edge after it.
- R9: DIN is ignored from the eighth control bit until the LSB decision.
- R10: PD1:PD0 take effect on the eighth control bit. 11 gives powered and serial clock. 10 gives powered and internal clock. 00 gives power-down between conversions and keeps the clock mode. 01 changes nothing. `bias_en_o` is high while powered or while a frame is under way. `clk_int_sel_o` shows the clock mode.
- R11: A new start bit may be latched on the rising edge right after the LSB edge, so frames can follow each other every 24 serial clocks.
- R12: After reset the output enables, busy, sample, `dac_code_o`, `bias_en_o` and `clk_int_sel_o` are zero, and the multiplexer selects input 0 against common.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Active-low chip select |
| dclk_i | input | 1 | Serial clock |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out |
| dout_oe_o | output | 1 | Output enable for dout_o |
| busy_o | output | 1 | Busy indication |
| busy_oe_o | output | 1 | Output enable for busy_o |
| pos_sel_o | output | 3 | Positive multiplexer input |
| neg_sel_o | output | 3 | Negative multiplexer input (differential) |
| neg_com_o | output | 1 | Negative side taken from common |
| sample_o | output | 1 | Acquire (high) / hold (low) |
| dac_code_o | output | CODE_W | Trial code to capacitor DAC |
| cmp_i | input | 1 | Comparator: held sample >= trial level |
| bias_en_o | output | 1 | Analog power enable |
| clk_int_sel_o | output | 1 | Internal conversion clock selected |

## Verification
The bound checker watches every cycle for the rules that hold at any time. Chip-select high must disable the outputs. Busy and sample may move only on the proper serial-clock edge and are never high together. The first trial must be the mid-scale code. Data-out and the clock-mode flag must change only after the right edge. Only the bench's scenarios can show that the search returns the correct word for a given analog level, including zero and full scale. They also cover the channel mapping in both input modes, garbage on DIN during a conversion, aborted frames, the sticky clock mode under power mode 00, and frames sent back to back.

// File: rtl/ser_sar_pkg.sv
package ser_sar_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_RECV = 2'd1,
        ST_ARM  = 2'd2,
        ST_CONV = 2'd3
    } seq_state_e;

    localparam logic [1:0] PD_AUTO   = 2'b00;
    localparam logic [1:0] PD_RSVD   = 2'b01;
    localparam logic [1:0] PD_INTCLK = 2'b10;
    localparam logic [1:0] PD_ALWAYS = 2'b11;

endpackage

// File: rtl/ser_sar_edge.sv
module ser_sar_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    output logic rise_o,
    output logic fall_o
);
    logic sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_i;
    end

    assign rise_o = sclk_i & ~sclk_q;
    assign fall_o = ~sclk_i & sclk_q;
endmodule

// File: rtl/ser_sar_chmap.sv
module ser_sar_chmap #(
    parameter int unsigned SEL_W = 3
) (
    input  logic [SEL_W-1:0] addr_i,
    input  logic             single_i,
    output logic [SEL_W-1:0] pos_o,
    output logic [SEL_W-1:0] neg_o,
    output logic             com_o
);
    localparam int unsigned PAIR_W = SEL_W - 1;

    logic [PAIR_W-1:0] pair;
    logic              swap;

    assign pair  = addr_i[PAIR_W-1:0];
    assign swap  = addr_i[SEL_W-1];
    // single-ended and differential share the positive mapping
    assign pos_o = {pair, swap};
    assign neg_o = single_i ? '0 : {pair, ~swap};
    assign com_o = single_i;
endmodule

// File: rtl/ser_sar_step.sv
module ser_sar_step #(
    parameter int unsigned CODE_W = 16,
    parameter int unsigned IDX_W  = $clog2(CODE_W)
) (
    input  logic [CODE_W-1:0] trial_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              keep_i,
    output logic [CODE_W-1:0] result_o,
    output logic [CODE_W-1:0] next_o
);
    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
        logic here;
        logic below;
        assign here = (idx_i == IDX_W'(b));
        if (b < CODE_W - 1) begin : g_mid
            assign below = (idx_i == IDX_W'(b + 1));
        end else begin : g_top
            assign below = 1'b0;
        end
        assign result_o[b] = here ? keep_i : trial_i[b];
        assign next_o[b]   = below | result_o[b];
    end
endmodule

// File: rtl/ser_sar_seq.sv
module ser_sar_seq
    import ser_sar_pkg::*;
#(
    parameter int unsigned CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              dclk_i,
    input  logic              din_i,
    output logic              dout_o,
    output logic              dout_oe_o,
    output logic              busy_o,
    output logic              busy_oe_o,
    output logic [2:0]        pos_sel_o,
    output logic [2:0]        neg_sel_o,
    output logic              neg_com_o,
    output logic              sample_o,
    output logic [CODE_W-1:0] dac_code_o,
    input  logic              cmp_i,
    output logic              bias_en_o,
    output logic              clk_int_sel_o
);
    localparam int unsigned SEL_W  = 3;
    localparam int unsigned CTRL_W = 8;
    localparam int unsigned CNT_W  = $clog2(CTRL_W + 1);
    localparam int unsigned IDX_W  = $clog2(CODE_W);
    localparam int unsigned SHR_W  = 2;
    localparam int unsigned AT_CH  = 4;
    localparam int unsigned AT_SGL = 6;

    typedef struct packed {
        seq_state_e         state;
        logic [CNT_W-1:0]   cnt;
        logic [SHR_W-1:0]   shr;
        logic [SEL_W-1:0]   ch;
        logic               sgl;
        logic               pwr;
        logic               intclk;
        logic               sample;
        logic               busy;
        logic               dout;
        logic               oe;
        logic [IDX_W-1:0]   idx;
        logic [CODE_W-1:0]  trial;
        logic               bias;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        state: ST_HUNT, cnt: '0, shr: '0, ch: '0, sgl: 1'b1, pwr: 1'b0,
        intclk: 1'b0, sample: 1'b0, busy: 1'b0, dout: 1'b0, oe: 1'b0,
        idx: '0, trial: '0, bias: 1'b0
    };

    seq_t q, d;
    logic rise, fall;
    logic [CODE_W-1:0] step_res, step_nxt;
    logic [CNT_W-1:0]  cnt_inc;
    logic [1:0]        pd;

    ser_sar_edge edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (dclk_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    ser_sar_step #(.CODE_W(CODE_W), .IDX_W(IDX_W)) step_i (
        .trial_i  (q.trial),
        .idx_i    (q.idx),
        .keep_i   (cmp_i),
        .result_o (step_res),
        .next_o   (step_nxt)
    );

    ser_sar_chmap #(.SEL_W(SEL_W)) map_i (
        .addr_i   (q.ch),
        .single_i (q.sgl),
        .pos_o    (pos_sel_o),
        .neg_o    (neg_sel_o),
        .com_o    (neg_com_o)
    );

    assign cnt_inc = q.cnt + CNT_W'(1);
    assign pd      = {q.shr[0], din_i};

    always_comb begin
        d = q;
        if (cs_n_i) begin
            d.state  = ST_HUNT;
            d.cnt    = '0;
            d.sample = 1'b0;
            d.busy   = 1'b0;
            d.dout   = 1'b0;
            d.oe     = 1'b0;
        end else begin
            d.oe = 1'b1;
            if (rise) begin
                case (q.state)
                    ST_HUNT: begin
                        if (din_i) begin
                            d.state = ST_RECV;
                            d.cnt   = CNT_W'(1);
                        end
                    end
                    ST_RECV: begin
                        d.shr = {q.shr[SHR_W-2:0], din_i};
                        d.cnt = cnt_inc;
                        if (cnt_inc == CNT_W'(AT_CH)) begin
                            d.ch     = {q.shr, din_i};
                            d.sample = 1'b1;
                        end
                        if (cnt_inc == CNT_W'(AT_SGL)) begin
                            d.sgl = din_i;
                        end
                        if (cnt_inc == CNT_W'(CTRL_W)) begin
                            d.sample = 1'b0;
                            d.state  = ST_ARM;
                            case (pd)
                                PD_ALWAYS: begin d.pwr = 1'b1; d.intclk = 1'b0; end
                                PD_INTCLK: begin d.pwr = 1'b1; d.intclk = 1'b1; end
                                PD_AUTO:   d.pwr = 1'b0;
                                default:   ;
                            endcase
                        end
                    end
                    default: ;
                endcase
            end
            if (fall) begin
                case (q.state)
                    ST_ARM: begin
                        d.busy  = 1'b1;
                        d.dout  = 1'b0;
                        d.trial = {1'b1, {(CODE_W-1){1'b0}}};
                        d.idx   = IDX_W'(CODE_W - 1);
                        d.state = ST_CONV;
                    end
                    ST_CONV: begin
                        d.busy  = 1'b0;
                        d.dout  = cmp_i;
                        d.trial = step_nxt;
                        if (q.idx == '0) d.state = ST_HUNT;
                        else             d.idx   = q.idx - IDX_W'(1);
                    end
                    default: d.dout = 1'b0;
                endcase
            end
        end
        d.bias = d.pwr | (d.state != ST_HUNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign dout_o        = q.dout;
    assign dout_oe_o     = q.oe;
    assign busy_o        = q.busy;
    assign busy_oe_o     = q.oe;
    assign sample_o      = q.sample;
    assign dac_code_o    = q.trial;
    assign bias_en_o     = q.bias;
    assign clk_int_sel_o = q.intclk;
endmodule

// File: rtl/ser_sar_seq_chk.sv
module ser_sar_seq_chk #(
    parameter int unsigned CODE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_i,
    input logic              dclk_i,
    input logic              dout_o,
    input logic              dout_oe_o,
    input logic              busy_o,
    input logic              busy_oe_o,
    input logic              sample_o,
    input logic [CODE_W-1:0] dac_code_o,
    input logic              clk_int_sel_o
);
    // R1
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> (!dout_oe_o && !busy_oe_o && !busy_o && !sample_o));

    // R6
    busy_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(dclk_i, 2) && !$past(dclk_i) && !$past(cs_n_i)));

    // R6
    busy_off_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (($past(dclk_i, 2) && !$past(dclk_i)) || $past(cs_n_i)));

    // R5
    sample_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_o) |-> (!$past(dclk_i, 2) && $past(dclk_i)));

    // R5
    sample_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_o && busy_o));

    // R7
    first_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (dac_code_o == {1'b1, {(CODE_W-1){1'b0}}}));

    // R8
    dout_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout_o) |-> (($past(dclk_i, 2) && !$past(dclk_i)) || $past(cs_n_i)));

    // R10
    clkmode_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_int_sel_o) |-> (!$past(dclk_i, 2) && $past(dclk_i)));
endmodule

bind ser_sar_seq ser_sar_seq_chk #(.CODE_W(CODE_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n_i        (cs_n_i),
    .dclk_i        (dclk_i),
    .dout_o        (dout_o),
    .dout_oe_o     (dout_oe_o),
    .busy_o        (busy_o),
    .busy_oe_o     (busy_oe_o),
    .sample_o      (sample_o),
    .dac_code_o    (dac_code_o),
    .clk_int_sel_o (clk_int_sel_o)
);

// File: tb/ser_sar_seq_tb_top.sv
module ser_sar_seq_tb_top;
    localparam int unsigned CODE_W = 16;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, dclk = 1'b0, din = 1'b0, cmp;
    logic dout, dout_oe, busy, busy_oe, sample, neg_com, bias, intclk;
    logic [2:0] pos, neg;
    logic [CODE_W-1:0] dac;

    always #5 clk = ~clk;

    ser_sar_seq #(.CODE_W(CODE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .dclk_i(dclk), .din_i(din),
        .dout_o(dout), .dout_oe_o(dout_oe), .busy_o(busy), .busy_oe_o(busy_oe),
        .pos_sel_o(pos), .neg_sel_o(neg), .neg_com_o(neg_com), .sample_o(sample),
        .dac_code_o(dac), .cmp_i(cmp), .bias_en_o(bias), .clk_int_sel_o(intclk)
    );

    // analog levels of the eight inputs, in code units
    int vals [8] = '{32'h1234, 32'hFFFF, 32'h8001, 32'h4F00, 0, 32'h7FFF, 32'hA5A5, 1};

    function automatic int level(int p, int n, bit com);
        if (com) return vals[p];
        if (vals[p] > vals[n]) return vals[p] - vals[n];
        return 0;
    endfunction

    always_comb cmp = (level(int'(pos), int'(neg), neg_com) >= int'(dac));

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ph, m_nb, m_byte, m_ch, m_j, m_w, m_dac;
    bit m_sgl, m_pwr, m_ick, m_samp, m_busy, m_dout, m_oe, m_bias, m_prev;

    function automatic int m_pos(int a); return 2 * (a % 4) + a / 4; endfunction
    function automatic int m_neg(int a, bit s); return s ? 0 : 2 * (a % 4) + 1 - a / 4; endfunction
    function automatic int m_trial(int w, int j);
        int hi;
        hi = (j == 0) ? 0 : ((w >> (16 - j)) << (16 - j));
        return (j < 16) ? (hi | (1 << (15 - j))) : w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_nb = 0; m_byte = 0; m_ch = 0; m_j = 0; m_w = 0; m_dac = 0;
            m_sgl = 1; m_pwr = 0; m_ick = 0; m_samp = 0; m_busy = 0; m_dout = 0;
            m_oe = 0; m_prev = 0;
        end else begin
            if (cs_n) begin
                m_ph = 0; m_samp = 0; m_busy = 0; m_dout = 0; m_oe = 0;
            end else begin
                m_oe = 1;
                if (dclk && !m_prev) begin
                    if (m_ph == 0 && din) begin
                        m_ph = 1; m_nb = 1; m_byte = 1;
                    end else if (m_ph == 1) begin
                        m_byte = m_byte * 2 + int'(din);
                        m_nb++;
                        if (m_nb == 4) begin m_ch = m_byte % 8; m_samp = 1; end
                        if (m_nb == 6) m_sgl = din;
                        if (m_nb == 8) begin
                            m_samp = 0; m_ph = 2;
                            case (m_byte % 4)
                                3: begin m_pwr = 1; m_ick = 0; end
                                2: begin m_pwr = 1; m_ick = 1; end
                                0: m_pwr = 0;
                                default: ;
                            endcase
                        end
                    end
                end
                if (!dclk && m_prev) begin
                    if (m_ph == 2) begin
                        m_busy = 1; m_dout = 0; m_j = 0; m_ph = 3;
                        m_w = level(m_pos(m_ch), m_neg(m_ch, m_sgl), m_sgl);
                        m_dac = m_trial(m_w, 0);
                    end else if (m_ph == 3) begin
                        m_busy = 0;
                        m_dout = m_w[15 - m_j];
                        m_j++;
                        m_dac = m_trial(m_w, m_j);
                        if (m_j == 16) m_ph = 0;
                    end else begin
                        m_dout = 0;
                    end
                end
            end
            m_bias = m_pwr | (m_ph != 0);
            m_prev = dclk;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1", "dout_oe", int'(dout_oe), int'(m_oe));
            check("R1", "busy_oe", int'(busy_oe), int'(m_oe));
            check("R6", "busy", int'(busy), int'(m_busy));
            check("R5", "sample", int'(sample), int'(m_samp));
            check(m_sgl ? "R3" : "R4", "pos_sel", int'(pos), m_pos(m_ch));
            check(m_sgl ? "R3" : "R4", "neg_sel", int'(neg), m_neg(m_ch, m_sgl));
            check(m_sgl ? "R3" : "R4", "neg_com", int'(neg_com), int'(m_sgl));
            check("R7", "dac_code", int'(dac), m_dac);
            check((m_ph == 3) ? "R7" : "R8", "dout", int'(dout), int'(m_dout));
            check("R10", "bias_en", int'(bias), int'(m_bias));
            check("R10", "clk_int_sel", int'(intclk), int'(m_ick));
        end
    end

    // ---------------- stimulus ----------------
    bit tx_q [$];
    bit rx_q [$];

    task automatic push_zeros(int n); for (int i = 0; i < n; i++) tx_q.push_back(1'b0); endtask
    task automatic push_ones(int n);  for (int i = 0; i < n; i++) tx_q.push_back(1'b1); endtask
    task automatic push_byte(logic [7:0] b);
        for (int i = 7; i >= 0; i--) tx_q.push_back(b[i]);
    endtask

    task automatic run_stream();
        rx_q.delete();
        foreach (tx_q[e]) begin
            @(negedge clk); din = tx_q[e];
            repeat (2) @(negedge clk);
            rx_q.push_back(dout);
            dclk = 1'b1;
            repeat (3) @(negedge clk);
            dclk = 1'b0;
        end
        tx_q.delete();
        @(negedge clk); din = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic int word_at(int s);
        int w = 0;
        for (int j = 0; j < 16; j++) w = (w << 1) | int'(rx_q[s + 9 + j]);
        return w;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R12 watchdog expired: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12", "reset dout_oe", int'(dout_oe), 0);
        check("R12", "reset busy_oe", int'(busy_oe), 0);
        check("R12", "reset busy", int'(busy), 0);
        check("R12", "reset sample", int'(sample), 0);
        check("R12", "reset dac", int'(dac), 0);
        check("R12", "reset bias", int'(bias), 0);
        check("R12", "reset intclk", int'(intclk), 0);
        check("R12", "reset pos", int'(pos), 0);
        check("R12", "reset com", int'(neg_com), 1);

        cs_n = 1'b0;
        repeat (2) @(negedge clk);

        // R2: leading zeros, single-ended input 3 (A=101), PD=11
        push_zeros(3); push_byte(8'hD7); push_zeros(27); run_stream();
        check("R2", "start after zeros word", word_at(3), 32'h4F00);
        check("R3", "single-ended pos for A=101", int'(pos), 3);
        check("R3", "single-ended com", int'(neg_com), 1);
        for (int k = 0; k < 3; k++) check("R8", "zero fill after LSB", int'(rx_q[3 + 25 + k]), 0);
        check("R10", "PD=11 bias", int'(bias), 1);
        check("R10", "PD=11 intclk", int'(intclk), 0);

        // R9: differential pair 1, DIN high during the whole conversion, PD=00
        push_byte(8'h90); push_ones(16); push_zeros(10); run_stream();
        check("R9", "word with DIN garbage", word_at(0), 32'h3101);
        check("R9", "no frame started by garbage", int'(sample), 0);
        check("R4", "diff pos", int'(pos), 2);
        check("R4", "diff neg", int'(neg), 3);
        check("R4", "diff com", int'(neg_com), 0);
        check("R10", "PD=00 bias", int'(bias), 0);

        // R4 reversed polarity gives a negative level: code zero; PD=10
        push_byte(8'hD2); push_zeros(26); run_stream();
        check("R4", "reversed pair word", word_at(0), 0);
        check("R4", "reversed pos", int'(pos), 3);
        check("R4", "reversed neg", int'(neg), 2);
        check("R10", "PD=10 intclk", int'(intclk), 1);
        check("R10", "PD=10 bias", int'(bias), 1);

        // R7 full scale on input 1 (A=100), PD=00 keeps clock mode
        push_byte(8'hC4); push_zeros(26); run_stream();
        check("R7", "full-scale word", word_at(0), 32'hFFFF);
        check("R3", "single-ended pos for A=100", int'(pos), 1);
        check("R10", "PD=00 keeps intclk", int'(intclk), 1);
        check("R10", "PD=00 bias off", int'(bias), 0);

        // R10 reserved code changes nothing
        push_byte(8'hC5); push_zeros(26); run_stream();
        check("R7", "repeat full-scale word", word_at(0), 32'hFFFF);
        check("R10", "PD=01 intclk", int'(intclk), 1);
        check("R10", "PD=01 bias", int'(bias), 0);

        // R1 abort inside the control byte, then clocks with CS high
        tx_q.push_back(1'b1); tx_q.push_back(1'b0); tx_q.push_back(1'b1); run_stream();
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "abort dout_oe", int'(dout_oe), 0);
        check("R1", "abort busy_oe", int'(busy_oe), 0);
        push_byte(8'hFF); run_stream();
        check("R1", "CS high sample", int'(sample), 0);
        cs_n = 1'b0;
        push_byte(8'h97); push_zeros(26); run_stream();
        check("R1", "clean frame after abort", word_at(0), 32'h8001);

        // R1 abort inside a conversion
        push_byte(8'hE7); push_zeros(5); run_stream();
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "mid-conversion busy", int'(busy), 0);
        check("R1", "mid-conversion busy_oe", int'(busy_oe), 0);
        cs_n = 1'b0;

        // R11 back-to-back 24-clock frames: inputs 2 then 5
        push_byte(8'h97); push_zeros(16); push_byte(8'hE7); push_zeros(18); run_stream();
        check("R11", "first of back-to-back", word_at(0), 32'h8001);
        check("R11", "second of back-to-back", word_at(24), 32'h7FFF);
        check("R10", "PD=11 restores serial clock", int'(intclk), 0);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule